// File: doc/BRIEF.md
# HDLC Frame Transmit Encoder

This block turns a packet payload into the bit-stuffed body of an HDLC frame. Payload bytes arrive one per handshake beat, with a start marker on the first byte and an end marker on the last. The encoder runs a 16-bit frame check over the accepted payload and appends it. It inserts a zero after every run of five ones, closes the frame with a flag, and repacks the resulting bit stream into bytes on a valid/ready output.

The preamble flags that open a frame come from a separate channel-access sequencer, so the encoder emits nothing between frames. NRZI coding and modulation happen further down the line. Each closed frame ends on a byte boundary, so the next frame starts cleanly in a fresh output byte.

Top module: `hdlc_tx_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Bits are serialized least significant bit first. Output byte k holds stream bits 8k to 8k+7, with the earliest bit in bit 0.
- R3: After five consecutive ones, a single zero is inserted and the run count restarts. The run carries across payload byte boundaries and into and through both check bytes.
- R4: The frame check starts from 0xFFFF and uses the right-shifting polynomial 0x8408 over the accepted payload bits. It is inverted and appended, low byte first, and both check bytes are stuffed.
- R5: After the check bytes comes an unstuffed flag 0x7E. If the frame does not end on a byte boundary, it is padded with the leading bits of 0x7E (0, 1, 1, ... taken LSB first) until it does.
- R6: A frame whose first byte carries both `in_sof` and `in_eof` (a one-byte payload) produces no output at all.
- R7: Payload bytes beyond `MAX_LEN` are discarded. The frame is still closed at the end marker, with the check computed over the first `MAX_LEN` bytes only.
- R8: Bytes offered while no frame is open and without `in_sof` are accepted and ignored. They produce no output and do not disturb the next frame.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R10: No payload byte enters the stuffing stage while 8 or more encoded bits are waiting. With the output stalled, `in_ready` falls to 0 once a byte is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Payload byte taken on this edge when in_valid is 1 |
| out_valid | output | 1 | Encoded byte available |
| out_data | output | 8 | Encoded byte, earliest bit in bit 0 |
| out_ready | input | 1 | Downstream takes the encoded byte |

## Verification
The hardest state to reach is a long run of ones that straddles the last payload byte, both check bytes and the closing flag. The stuffing position then moves across byte edges and sets how much padding the frame needs. Random payloads of every length from 2 to the limit, together with all-ones and flag-valued payloads, push the run counter through those boundaries. A random downstream ready, plus one fully stalled window, makes the backlog reach the level where intake must stop.

// File: rtl/hdlc_tx_pkg.sv
// Shared constants and types for the HDLC transmit encoder.
package hdlc_tx_pkg;
    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    localparam logic [15:0] CRC_POLY   = 16'h8408;
    localparam int RUN_LIMIT = 5;
    localparam int RUN_W     = $clog2(RUN_LIMIT + 1);
    localparam int SBITS_W   = 10;                  // 8 data bits + up to 2 stuffed zeros
    localparam int SNUM_W    = $clog2(SBITS_W + 1);
    localparam int ACC_W     = 24;                  // worst case: 7 backlog + 8 flag + 7 pad
    localparam int FILL_W    = $clog2(ACC_W + 1);

    typedef enum logic [1:0] {
        PK_DATA   = 2'd0,
        PK_FCS_LO = 2'd1,
        PK_FCS_HI = 2'd2,
        PK_CLOSE  = 2'd3
    } pk_state_e;
endpackage

// File: rtl/hdlc_tx_crc.sv
// Byte-wide reflected CRC step.
// Assumes: bits enter LSB first; POLY is given in right-shifting form.
module hdlc_tx_crc #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'h8408
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       data_in,
    output logic [CRC_W-1:0] crc_out
);
    // Fold eight data bits into the remainder.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ data_in[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY[CRC_W-1:0];
        end
        crc_out = c;
    end
endmodule

// File: rtl/hdlc_tx_stuff.sv
// Zero-insertion for one byte, LSB first.
// Outputs the stuffed bits packed from bit 0, their count and the new run length.
// Assumes: run_in < RUN_LIMIT; unused output bits are zero.
module hdlc_tx_stuff
    import hdlc_tx_pkg::*;
(
    input  logic [7:0]         data_in,
    input  logic [RUN_W-1:0]   run_in,
    output logic [SBITS_W-1:0] bits_out,
    output logic [SNUM_W-1:0]  nbits_out,
    output logic [RUN_W-1:0]   run_out
);
    // Walk the byte, placing a zero after each fifth consecutive one.
    always_comb begin
        logic [SNUM_W-1:0] n;
        logic [RUN_W-1:0]  r;
        bits_out = '0;
        n = '0;
        r = run_in;
        for (int i = 0; i < 8; i++) begin
            bits_out[n] = data_in[i];
            n = n + 1'b1;
            if (data_in[i]) r = r + 1'b1;
            else            r = '0;
            if (r == RUN_W'(RUN_LIMIT)) begin
                n = n + 1'b1;          // inserted zero already cleared
                r = '0;
            end
        end
        nbits_out = n;
        run_out   = r;
    end
endmodule

// File: rtl/hdlc_tx_gate.sv
// Frame intake: tracks frame boundaries, holds one byte back so a
// one-byte frame can be dropped, and discards bytes past MAX_LEN.
// Assumes: MAX_LEN >= 2; in_sof only counts when no frame is open.
module hdlc_tx_gate #(
    parameter int MAX_LEN = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    input  logic       core_ready,
    output logic       push,
    output logic [7:0] push_data,
    output logic       push_last,
    output logic       hold_pending,
    output logic       frame_open
);
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic             hold_v, hold_last, in_frame;
    logic [7:0]       hold_d;
    logic [CNT_W-1:0] cnt;
    logic             fire, start, adv, drop_end;

    // Handshake and event decode.
    always_comb begin
        in_ready = !hold_last && (!hold_v || core_ready);
        fire     = in_valid && in_ready;
        start    = fire && in_sof && !in_frame;
        adv      = fire && in_frame && (cnt < CNT_W'(MAX_LEN));
        drop_end = fire && in_frame && (cnt >= CNT_W'(MAX_LEN)) && in_eof;
        push     = hold_v && core_ready && (hold_last || adv);
    end

    assign push_data    = hold_d;
    assign push_last    = hold_last;
    assign hold_pending = hold_v;
    assign frame_open   = in_frame;

    // Hold register, length count and frame-open tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v    <= 1'b0;
            hold_last <= 1'b0;
            hold_d    <= '0;
            in_frame  <= 1'b0;
            cnt       <= '0;
        end else begin
            if (push) begin
                hold_v    <= 1'b0;
                hold_last <= 1'b0;
            end
            if (start && !in_eof) begin
                hold_v    <= 1'b1;
                hold_d    <= in_data;
                hold_last <= 1'b0;
                cnt       <= CNT_W'(1);
                in_frame  <= 1'b1;
            end
            if (adv) begin
                hold_v    <= 1'b1;
                hold_d    <= in_data;
                hold_last <= in_eof;
                cnt       <= cnt + 1'b1;
                if (in_eof) in_frame <= 1'b0;
            end
            if (drop_end) begin
                hold_last <= 1'b1;
                in_frame  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_packer.sv
// Frame body sequencer and bit accumulator: stuffs payload and check
// bytes, appends the closing flag plus alignment pad, emits bytes.
// Assumes: push only while core_ready is high.
module hdlc_tx_packer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [7:0]        push_data,
    input  logic              push_last,
    output logic              core_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic [FILL_W-1:0] fill_level,
    output logic              close_step
);
    pk_state_e          state;
    logic [ACC_W-1:0]   acc;
    logic [FILL_W-1:0]  fill;
    logic [15:0]        crc, crc_next;
    logic [RUN_W-1:0]   run, srun;
    logic [7:0]         sel_byte;
    logic [SBITS_W-1:0] sbits;
    logic [SNUM_W-1:0]  snum;
    logic               emit, room;
    logic [ACC_W-1:0]   stuff_word, close_word;
    logic [FILL_W-1:0]  total, close_fill;
    logic [2:0]         padlen;
    logic [7:0]         padbits;

    hdlc_tx_crc #(.CRC_W(16), .POLY(CRC_POLY)) u_crc (
        .crc_in (crc),
        .data_in(push_data),
        .crc_out(crc_next)
    );

    hdlc_tx_stuff u_stuff (
        .data_in  (sel_byte),
        .run_in   (run),
        .bits_out (sbits),
        .nbits_out(snum),
        .run_out  (srun)
    );

    // Pick the byte to stuff: payload or inverted check halves.
    always_comb begin
        case (state)
            PK_FCS_LO: sel_byte = ~crc[7:0];
            PK_FCS_HI: sel_byte = ~crc[15:8];
            default:   sel_byte = push_data;
        endcase
    end

    // Output, flow control and word alignment for appends.
    always_comb begin
        out_valid  = fill >= FILL_W'(8);
        out_data   = acc[7:0];
        emit       = out_valid && out_ready;
        room       = fill < FILL_W'(8);
        core_ready = room && (state == PK_DATA);
        close_step = room && (state == PK_CLOSE);
        stuff_word = ACC_W'(sbits) << fill;
        total      = fill + FILL_W'(8);
        padlen     = 3'd0 - total[2:0];
        padbits    = FLAG_BYTE & ~(8'hFF << padlen);
        close_word = (ACC_W'(FLAG_BYTE) << fill) | (ACC_W'(padbits) << total);
        close_fill = total + FILL_W'(padlen);
        fill_level = fill;
    end

    // Sequence the frame body and shift bits through the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PK_DATA;
            acc   <= '0;
            fill  <= '0;
            crc   <= CRC_PRESET;
            run   <= '0;
        end else if (emit) begin
            acc  <= acc >> 8;
            fill <= fill - FILL_W'(8);
        end else if (room) begin
            case (state)
                PK_DATA: begin
                    if (push) begin
                        acc  <= acc | stuff_word;
                        fill <= fill + FILL_W'(snum);
                        crc  <= crc_next;
                        run  <= srun;
                        if (push_last) state <= PK_FCS_LO;
                    end
                end
                PK_FCS_LO: begin
                    acc   <= acc | stuff_word;
                    fill  <= fill + FILL_W'(snum);
                    run   <= srun;
                    state <= PK_FCS_HI;
                end
                PK_FCS_HI: begin
                    acc   <= acc | stuff_word;
                    fill  <= fill + FILL_W'(snum);
                    run   <= srun;
                    state <= PK_CLOSE;
                end
                default: begin
                    acc   <= acc | close_word;
                    fill  <= close_fill;
                    crc   <= CRC_PRESET;
                    run   <= '0;
                    state <= PK_DATA;
                end
            endcase
        end
    end
endmodule

// File: rtl/hdlc_tx_encoder.sv
// HDLC transmit encoder top: intake gate feeding the stuffing packer.
// Assumes: well-formed start/end markers; opening flags come from elsewhere.
module hdlc_tx_encoder
    import hdlc_tx_pkg::*;
#(
    parameter int MAX_LEN = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready
);
    logic              push, push_last, core_ready;
    logic [7:0]        push_data;
    logic              hold_pending, frame_open, close_step;
    logic [FILL_W-1:0] fill_level;

    hdlc_tx_gate #(.MAX_LEN(MAX_LEN)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .in_ready    (in_ready),
        .core_ready  (core_ready),
        .push        (push),
        .push_data   (push_data),
        .push_last   (push_last),
        .hold_pending(hold_pending),
        .frame_open  (frame_open)
    );

    hdlc_tx_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .push_last (push_last),
        .core_ready(core_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .fill_level(fill_level),
        .close_step(close_step)
    );
endmodule

// File: rtl/hdlc_tx_encoder_check.sv
// Protocol checker for the HDLC transmit encoder, bound to the top.
module hdlc_tx_encoder_check #(
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sof,
    input logic              in_eof,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              push,
    input logic              hold_pending,
    input logic              frame_open,
    input logic [FILL_W-1:0] fill_level,
    input logic              close_step
);
    // R1: reset leaves the output idle and intake open.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready));

    // R9: a stalled output byte stays put.
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10: nothing enters the stuffer while a full byte waits.
    assert_no_push_backlog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill_level < FILL_W'(8)));

    // R5: flag plus pad leaves the stream byte aligned.
    assert_close_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        close_step |=> (fill_level[2:0] == 3'd0));

    // R6: a one-byte frame leaves nothing held.
    assert_short_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_sof && in_eof && !frame_open) |=> !hold_pending);
endmodule

bind hdlc_tx_encoder hdlc_tx_encoder_check #(.FILL_W(hdlc_tx_pkg::FILL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sof      (in_sof),
    .in_eof      (in_eof),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .push        (push),
    .hold_pending(hold_pending),
    .frame_open  (frame_open),
    .fill_level  (fill_level),
    .close_step  (close_step)
);

// File: tb/hdlc_tx_encoder_test.sv
`timescale 1ns/1ps
module hdlc_tx_encoder_test;
    localparam int MAX = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int ready_mode = 1;       // 0 random, 1 always, 2 never
    bit send_done;

    logic [7:0] pay_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] got_q[$];
    bit         bq[$];
    int         run_len;

    always #4 clk = ~clk;     // 125 MHz

    hdlc_tx_encoder #(.MAX_LEN(MAX)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    // Downstream: choose ready, then record the byte the next edge takes.
    always @(negedge clk) begin
        case (ready_mode)
            0:       out_ready = ($urandom % 4) != 0;
            1:       out_ready = 1'b1;
            default: out_ready = 1'b0;
        endcase
        if (rst_n && out_valid && out_ready) got_q.push_back(out_data);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Expected stream model -------------------------------------------
    task automatic put_stuffed(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            bq.push_back(b[i]);
            if (b[i]) run_len++; else run_len = 0;
            if (run_len == 5) begin bq.push_back(1'b0); run_len = 0; end
        end
    endtask

    task automatic build_expected();
        logic [15:0] c;
        int n;
        int pad;
        bq.delete();
        exp_q.delete();
        run_len = 0;
        c = 16'hFFFF;
        n = (pay_q.size() > MAX) ? MAX : pay_q.size();
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                bit fb;
                fb = c[0] ^ pay_q[k][i];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
            put_stuffed(pay_q[k]);
        end
        c = ~c;
        put_stuffed(c[7:0]);
        put_stuffed(c[15:8]);
        for (int i = 0; i < 8; i++) bq.push_back(8'h7E >> i);
        pad = (8 - (bq.size() % 8)) % 8;
        for (int i = 0; i < pad; i++) bq.push_back(8'h7E >> i);
        for (int k = 0; k < bq.size(); k += 8) begin
            logic [7:0] b;
            for (int j = 0; j < 8; j++) b[j] = bq[k + j];
            exp_q.push_back(b);
        end
    endtask

    // Stimulus ---------------------------------------------------------
    task automatic drive_byte(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic send_payload();
        for (int k = 0; k < pay_q.size(); k++)
            drive_byte(pay_q[k], k == 0, k == pay_q.size() - 1);
        send_done = 1'b1;
    endtask

    task automatic wait_drain();
        int t = 0;
        while (got_q.size() < exp_q.size() && t < 3000) begin @(negedge clk); t++; end
        repeat (40) @(negedge clk);
    endtask

    task automatic compare(input string req);
        int bad = -1;
        if (got_q.size() != exp_q.size()) begin
            check(1'b0, req, "frame length", got_q.size(), exp_q.size());
            return;
        end
        for (int k = 0; k < exp_q.size(); k++)
            if (bad < 0 && got_q[k] !== exp_q[k]) bad = k;
        if (bad < 0) check(1'b1, req, "frame bytes", 0, 0);
        else check(1'b0, req, $sformatf("byte %0d", bad), got_q[bad], exp_q[bad]);
    endtask

    task automatic run_frame(input string req);
        build_expected();
        got_q.delete();
        send_done = 1'b0;
        send_payload();
        wait_drain();
        compare(req);
    endtask

    // Watchdog ---------------------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R2 R4: minimal two-byte frame of zeros
        pay_q = '{8'h00, 8'h00};
        run_frame("R2_R4");

        // R3: ones run across byte boundaries
        pay_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_frame("R3");

        // R3 R5: flag-valued payload is stuffed, pad path exercised
        pay_q = '{8'h7E, 8'h7E, 8'h7E};
        run_frame("R3_R5");

        // R2: ascending bytes
        pay_q = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89};
        run_frame("R2");

        // R6: one-byte frame produces nothing
        got_q.delete();
        drive_byte(8'hA5, 1'b1, 1'b1);
        repeat (60) @(negedge clk);
        check(got_q.size() == 0, "R6", "bytes out for one-byte frame", got_q.size(), 0);
        pay_q = '{8'h3C, 8'hC3};
        run_frame("R6");

        // R8: stray bytes outside a frame are ignored
        got_q.delete();
        drive_byte(8'hFF, 1'b0, 1'b0);
        drive_byte(8'h55, 1'b0, 1'b1);
        drive_byte(8'hFF, 1'b0, 1'b0);
        repeat (60) @(negedge clk);
        check(got_q.size() == 0, "R8", "bytes out for stray input", got_q.size(), 0);
        pay_q = '{8'hF0, 8'h0F, 8'hFF};
        run_frame("R8");

        // R7: exactly MAX and overlong frames
        pay_q.delete();
        for (int k = 0; k < MAX; k++) pay_q.push_back(8'(k * 37 + 1));
        run_frame("R7");
        pay_q.delete();
        for (int k = 0; k < MAX + 5; k++) pay_q.push_back(8'(k * 53 + 9));
        run_frame("R7");

        // R9 R10: output stalled mid-frame
        ready_mode = 2;
        pay_q.delete();
        for (int k = 0; k < 10; k++) pay_q.push_back(8'hFF);
        build_expected();
        got_q.delete();
        send_done = 1'b0;
        fork
            send_payload();
        join_none
        repeat (200) @(negedge clk);
        begin
            logic [7:0] held;
            held = out_data;
            check(out_valid === 1'b1, "R9", "out_valid under stall", out_valid, 1);
            check(in_ready === 1'b0, "R10", "in_ready under stall", in_ready, 0);
            repeat (7) @(negedge clk);
            check(out_data === held, "R9", "out_data stable under stall", out_data, held);
        end
        ready_mode = 0;
        wait (send_done);
        wait_drain();
        compare("R9_R10");

        // Random frames with random downstream ready
        for (int f = 0; f < 30; f++) begin
            int len;
            len = 2 + ($urandom % (MAX + 3));
            pay_q.delete();
            for (int k = 0; k < len; k++) begin
                logic [7:0] b;
                b = ($urandom % 3 == 0) ? 8'hFF : 8'($urandom);
                pay_q.push_back(b);
            end
            run_frame((len > MAX) ? "R7" : "R3_R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule